// File: doc/BRIEF.md
# Counting Radix Sort Pass Engine

This block sorts a buffer of 64-bit unsigned keys held in on-chip memory by running least-significant-digit radix passes. Every pass works in sweeps. The engine first clears a per-digit count table. It then reads every key and counts how often each value of the selected digit occurs. Next it turns the table into bucket start addresses with an exclusive running sum. Finally it reads the keys a second time and writes each one to its bucket's current address, then moves that address up by one.

The memory sits outside the block as two banks. The engine has one read port and one write port, and each carries a bank bit. The first pass reads bank 0 and writes bank 1. Every later pass swaps the banks and moves to the next digit up. A single start pulse with a pass count of eight therefore sorts a buffer completely when the digit is 8 bits wide. A one-cycle done pulse marks the end of the final pass. Reads have a latency of one cycle: data for the address presented in one cycle is expected on the read data input in the next cycle.

Top module: `radix_sort_pass`

## Requirements
- R1: After reset, done, the read enable and the write enable are all low.
- R2: When a single pass runs with digit index d, the destination bank afterwards holds the keys in ascending order of key bits [d*DIGIT_W +: DIGIT_W].
- R3: Each bucket starts at an address equal to the number of keys whose digit is smaller. Once the running sum is complete, it equals the key count.
- R4: Keys whose digits are equal keep their input order in the output (stable placement).
- R5: Pass p reads bank (p mod 2), writes the other bank, and uses digit firstDigit+p. The result ends in bank (passCount mod 2). With enough passes to cover 64 bits, the keys end fully sorted in ascending order.
- R6: The count table starts from zero in every pass, so counts from an earlier pass or run never reach a later one.
- R7: Done is high for exactly one cycle, after the last key of the last pass has been written. No read or write follows until the next start.
- R8: Reads and writes touch only addresses below numKeys. The write bank always differs from the read bank. Each pass makes exactly numKeys writes.
- R9: The design works with a 13-bit digit width as well as with the default 8-bit width.
- R10: A start pulse that arrives while a sort is running has no effect on the result or on the timing.
- R11: With numKeys equal to 0 the engine makes no reads and no writes, and done still pulses.
- R12: Counting from the clock edge that samples start, done is seen after passCount*(2*2^DIGIT_W + 2*max(numKeys,1) + 2) edges. Each running-sum sweep takes 2^DIGIT_W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sort; sampled only while idle |
| firstDigit | input | SEL_W | Index of the digit used by the first pass |
| passCount | input | SEL_W | Number of passes; 0 is treated as 1 |
| numKeys | input | ADDR_W+1 | Number of keys in the buffer, at most 2^ADDR_W |
| done | output | 1 | One-cycle pulse when the final pass has finished |
| rdEn | output | 1 | Read request |
| rdBank | output | 1 | Bank being read |
| rdAddr | output | ADDR_W | Read address |
| rdData | input | KEY_W | Key returned one cycle after the request |
| wrEn | output | 1 | Write request |
| wrBank | output | 1 | Bank being written |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | KEY_W | Key being written |

## Verification
The bench runs the engine on these buffers:
- Uniform random keys under a full eight-pass sort. This proves that the passes compose into a correct sort.
- Keys whose low byte is drawn from only a few values, with random upper bits. This separates a stable placement from one that merely groups keys.
- A single pass on a higher digit. This exposes digit-select errors.
- A fully descending buffer, and a buffer of identical keys. These push every key into the extremes of the running sum.
- Zero keys and one key, which probe the boundaries of the sweep counters.
- A run that receives a stray start pulse.
- A five-pass run on a second instance with 13-bit digits, which tests the wide-digit table and the shift arithmetic.

Every run also checks the exact latency, the write count and the address ranges.

// File: rtl/radix_sort_pkg.sv
package radix_sort_pkg;
  // strobes from control to datapath, one per activity
  typedef struct packed {
    logic clrEn;     // zero one count-table entry
    logic cntRead;   // key read issued during histogram sweep
    logic pfxEn;     // running-sum step on one table entry
    logic scatRead;  // key read issued during placement sweep
  } sortStrobes_t;
endpackage

// File: rtl/radix_sort_ctrl.sv
module radix_sort_ctrl
  import radix_sort_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DIGIT_W = 8,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [SEL_W-1:0]   firstDigit,
  input  logic [SEL_W-1:0]   passCount,
  input  logic [ADDR_W:0]    numKeys,
  output sortStrobes_t       strobes,
  output logic [DIGIT_W-1:0] tblIdx,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [SEL_W-1:0]   curDigit,
  output logic               srcBank,
  output logic [ADDR_W:0]    nKeysQ,
  output logic               done
);
  localparam int IDX_W   = ((ADDR_W > DIGIT_W) ? ADDR_W : DIGIT_W) + 1;
  localparam int CW      = IDX_W + 1;
  localparam int BUCKETS = 1 << DIGIT_W;

  typedef enum logic [2:0] {
    S_IDLE, S_CLEAR, S_COUNT, S_CDRAIN, S_PREFIX, S_SCATTER, S_SDRAIN
  } phase_t;

  phase_t           state;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] passLeft;
  logic             keyLeft;
  logic             lastKey;
  logic             lastBucket;

  assign keyLeft    = CW'(idx) < CW'(nKeysQ);
  assign lastKey    = (CW'(idx) + CW'(1)) >= CW'(nKeysQ);
  assign lastBucket = idx == IDX_W'(BUCKETS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      idx      <= '0;
      passLeft <= '0;
      curDigit <= '0;
      srcBank  <= 1'b0;
      nKeysQ   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          curDigit <= firstDigit;
          passLeft <= (passCount == '0) ? SEL_W'(1) : passCount;
          nKeysQ   <= numKeys;
          srcBank  <= 1'b0;
          idx      <= '0;
          state    <= S_CLEAR;
        end
        S_CLEAR: begin
          idx   <= lastBucket ? '0 : idx + IDX_W'(1);
          state <= lastBucket ? S_COUNT : S_CLEAR;
        end
        S_COUNT: begin
          idx   <= lastKey ? '0 : idx + IDX_W'(1);
          state <= lastKey ? S_CDRAIN : S_COUNT;
        end
        S_CDRAIN: state <= S_PREFIX;
        S_PREFIX: begin
          idx   <= lastBucket ? '0 : idx + IDX_W'(1);
          state <= lastBucket ? S_SCATTER : S_PREFIX;
        end
        S_SCATTER: begin
          idx   <= lastKey ? '0 : idx + IDX_W'(1);
          state <= lastKey ? S_SDRAIN : S_SCATTER;
        end
        S_SDRAIN: begin
          if (passLeft == SEL_W'(1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            passLeft <= passLeft - SEL_W'(1);
            curDigit <= curDigit + SEL_W'(1);
            srcBank  <= ~srcBank;
            state    <= S_CLEAR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.clrEn    = state == S_CLEAR;
    strobes.cntRead  = (state == S_COUNT) && keyLeft;
    strobes.pfxEn    = state == S_PREFIX;
    strobes.scatRead = (state == S_SCATTER) && keyLeft;
  end

  assign tblIdx = idx[DIGIT_W-1:0];
  assign rdAddr = idx[ADDR_W-1:0];

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcBank != $past(srcBank)) |-> (state == S_CLEAR));
endmodule

// File: rtl/radix_sort_datapath.sv
module radix_sort_datapath
  import radix_sort_pkg::*;
#(
  parameter int KEY_W   = 64,
  parameter int ADDR_W  = 8,
  parameter int DIGIT_W = 8,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  sortStrobes_t       strobes,
  input  logic [DIGIT_W-1:0] tblIdx,
  input  logic [SEL_W-1:0]   curDigit,
  input  logic [ADDR_W:0]    nKeys,
  input  logic [KEY_W-1:0]   rdData,
  output logic               wrEn,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [KEY_W-1:0]   wrData
);
  localparam int BUCKETS = 1 << DIGIT_W;
  localparam int CNT_W   = ADDR_W + 1;
  localparam int SH_W    = SEL_W + $clog2(DIGIT_W + 1);

  logic [CNT_W-1:0]   tbl [BUCKETS];
  logic [CNT_W-1:0]   acc;
  logic               cntValid;
  logic               scatValid;
  logic [SH_W-1:0]    shiftAmt;
  logic [DIGIT_W-1:0] digitVal;

  assign shiftAmt = SH_W'(curDigit) * SH_W'(DIGIT_W);
  assign digitVal = DIGIT_W'(rdData >> shiftAmt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntValid  <= 1'b0;
      scatValid <= 1'b0;
      acc       <= '0;
    end else begin
      cntValid  <= strobes.cntRead;
      scatValid <= strobes.scatRead;
      if (strobes.clrEn)      acc <= '0;
      else if (strobes.pfxEn) acc <= acc + tbl[tblIdx];
    end
  end

  // count table: clear, histogram, exclusive running sum, placement bump
  always_ff @(posedge clk) begin
    if (strobes.clrEn)              tbl[tblIdx]   <= '0;
    else if (strobes.pfxEn)         tbl[tblIdx]   <= acc;
    else if (cntValid || scatValid) tbl[digitVal] <= tbl[digitVal] + CNT_W'(1);
  end

  assign wrEn   = scatValid;
  assign wrAddr = tbl[digitVal][ADDR_W-1:0];
  assign wrData = rdData;

  // R8
  wr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    scatValid |-> (tbl[digitVal] < nKeys));

  // R3
  prefix_total_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.scatRead && tblIdx == '0 && !scatValid) |-> (acc == nKeys));
endmodule

// File: rtl/radix_sort_pass.sv
module radix_sort_pass
  import radix_sort_pkg::*;
#(
  parameter int KEY_W   = 64,
  parameter int ADDR_W  = 8,
  parameter int DIGIT_W = 8,
  parameter int SEL_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SEL_W-1:0]  firstDigit,
  input  logic [SEL_W-1:0]  passCount,
  input  logic [ADDR_W:0]   numKeys,
  output logic              done,
  output logic              rdEn,
  output logic              rdBank,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [KEY_W-1:0]  rdData,
  output logic              wrEn,
  output logic              wrBank,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [KEY_W-1:0]  wrData
);
  sortStrobes_t       strobes;
  logic [DIGIT_W-1:0] tblIdx;
  logic [SEL_W-1:0]   curDigit;
  logic               srcBank;
  logic [ADDR_W:0]    nKeysQ;

  radix_sort_ctrl #(.ADDR_W(ADDR_W), .DIGIT_W(DIGIT_W), .SEL_W(SEL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .firstDigit(firstDigit),
    .passCount(passCount), .numKeys(numKeys), .strobes(strobes),
    .tblIdx(tblIdx), .rdAddr(rdAddr), .curDigit(curDigit),
    .srcBank(srcBank), .nKeysQ(nKeysQ), .done(done)
  );

  radix_sort_datapath #(.KEY_W(KEY_W), .ADDR_W(ADDR_W), .DIGIT_W(DIGIT_W),
                        .SEL_W(SEL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tblIdx(tblIdx),
    .curDigit(curDigit), .nKeys(nKeysQ), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign rdEn   = strobes.cntRead | strobes.scatRead;
  assign rdBank = srcBank;
  assign wrBank = ~srcBank;
endmodule

// File: tb/test_radix_sort_pass.sv
`timescale 1ns/1ps
module test_radix_sort_pass;
  localparam int DEPTH_A = 256;
  localparam int DEPTH_B = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  firstDigit = '0, passCount = '0;
  logic        startA = 1'b0, startB = 1'b0;
  logic [8:0]  numKeysA = '0;
  logic [6:0]  numKeysB = '0;
  logic        doneA, rdEnA, rdBankA, wrEnA, wrBankA;
  logic [7:0]  rdAddrA, wrAddrA;
  logic [63:0] rdDataA = '0, wrDataA;
  logic        doneB, rdEnB, rdBankB, wrEnB, wrBankB;
  logic [5:0]  rdAddrB, wrAddrB;
  logic [63:0] rdDataB = '0, wrDataB;

  logic [63:0] memA [2][DEPTH_A];
  logic [63:0] memB [2][DEPTH_B];
  logic [63:0] stim [DEPTH_A];
  logic [63:0] expv [DEPTH_A];

  int checks = 0, failures = 0;
  int wrCnt = 0, bad = 0, curN = 0;

  radix_sort_pass i_radix_sort_pass (
    .clk(clk), .rstN(rstN), .start(startA), .firstDigit(firstDigit),
    .passCount(passCount), .numKeys(numKeysA), .done(doneA),
    .rdEn(rdEnA), .rdBank(rdBankA), .rdAddr(rdAddrA), .rdData(rdDataA),
    .wrEn(wrEnA), .wrBank(wrBankA), .wrAddr(wrAddrA), .wrData(wrDataA));

  radix_sort_pass #(.ADDR_W(6), .DIGIT_W(13)) i_radix_sort_pass13 (
    .clk(clk), .rstN(rstN), .start(startB), .firstDigit(firstDigit),
    .passCount(passCount), .numKeys(numKeysB), .done(doneB),
    .rdEn(rdEnB), .rdBank(rdBankB), .rdAddr(rdAddrB), .rdData(rdDataB),
    .wrEn(wrEnB), .wrBank(wrBankB), .wrAddr(wrAddrB), .wrData(wrDataB));

  // memory models and traffic monitor (R8)
  always @(posedge clk) begin
    if (rdEnA) begin
      rdDataA <= memA[rdBankA][rdAddrA];
      if (int'(rdAddrA) >= curN) bad++;
    end
    if (wrEnA) begin
      memA[wrBankA][wrAddrA] = wrDataA;
      wrCnt++;
      if (int'(wrAddrA) >= curN || wrBankA == rdBankA) bad++;
    end
    if (rdEnB) begin
      rdDataB <= memB[rdBankB][rdAddrB];
      if (int'(rdAddrB) >= curN) bad++;
    end
    if (wrEnB) begin
      memB[wrBankB][wrAddrB] = wrDataB;
      wrCnt++;
      if (int'(wrAddrB) >= curN || wrBankB == rdBankB) bad++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fieldOf(logic [63:0] k, int first, int passes, int dw);
    int lo = first * dw;
    int bits = passes * dw;
    logic [63:0] v = (lo >= 64) ? 64'd0 : (k >> lo);
    if (bits < 64) v = v & ((64'd1 << bits) - 64'd1);
    return v;
  endfunction

  // stable insertion sort on the selected digit range
  task automatic sortRef(input int n, input int first, input int passes, input int dw);
    for (int i = 0; i < n; i++) expv[i] = stim[i];
    for (int i = 1; i < n; i++) begin
      logic [63:0] key = expv[i];
      int j = i - 1;
      while (j >= 0 && fieldOf(expv[j], first, passes, dw) > fieldOf(key, first, passes, dw)) begin
        expv[j+1] = expv[j];
        j--;
      end
      expv[j+1] = key;
    end
  endtask

  task automatic runSort(input int inst, input int first, input int passes,
                         input int n, input bit poke, input string tag);
    int dw = (inst == 0) ? 8 : 13;
    int buckets = 1 << dw;
    int k = 0;
    int mism = 0;
    int expLat;
    int outBank = passes % 2;
    bit seen = 1'b0;
    logic [63:0] act = '0, exp = '0;
    sortRef(n, first, passes, dw);
    for (int i = 0; i < DEPTH_A; i++) begin
      if (inst == 0) begin
        memA[0][i] = (i < n) ? stim[i] : 64'hBAD0_0000_0000_0000;
        memA[1][i] = 64'hBAD1_0000_0000_0000;
      end else if (i < DEPTH_B) begin
        memB[0][i] = (i < n) ? stim[i] : 64'hBAD0_0000_0000_0000;
        memB[1][i] = 64'hBAD1_0000_0000_0000;
      end
    end
    wrCnt = 0; bad = 0; curN = n;
    @(negedge clk);
    firstDigit = 4'(first);
    passCount  = 4'(passes);
    if (inst == 0) begin numKeysA = 9'(n); startA = 1'b1; end
    else begin numKeysB = 7'(n); startB = 1'b1; end
    @(posedge clk); #1;
    startA = 1'b0; startB = 1'b0;
    while (!seen && k < 150000) begin
      @(posedge clk); k++; #1;
      seen = (inst == 0) ? doneA : doneB;
      if (poke && k == 37) begin
        firstDigit = 4'd5; passCount = 4'd1;
        if (inst == 0) startA = 1'b1; else startB = 1'b1;
      end else begin
        startA = 1'b0; startB = 1'b0;
      end
    end
    expLat = passes * (2 * buckets + 2 * ((n > 0) ? n : 1) + 2);
    check(seen && k == expLat, "R12 latency", k, expLat);
    @(posedge clk); #1;
    if (inst == 0) check(!doneA && !rdEnA && !wrEnA, "R7 after done", {doneA, rdEnA, wrEnA}, 0);
    else           check(!doneB && !rdEnB && !wrEnB, "R7 after done", {doneB, rdEnB, wrEnB}, 0);
    check(wrCnt == n * passes && bad == 0, "R8 traffic", wrCnt + 1000000 * bad, n * passes);
    for (int i = 0; i < n; i++) begin
      logic [63:0] got = (inst == 0) ? memA[outBank][i] : memB[outBank][i];
      if (got !== expv[i]) begin
        if (mism == 0) begin act = got; exp = expv[i]; end
        mism++;
      end
    end
    check(mism == 0, tag, act, exp);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1
    check(!doneA && !rdEnA && !wrEnA && !doneB && !rdEnB && !wrEnB, "R1 reset",
          {doneA, rdEnA, wrEnA, doneB, rdEnB, wrEnB}, 0);

    // R2 R5: random keys, full eight-pass sort
    for (int i = 0; i < 200; i++) stim[i] = {$urandom, $urandom};
    runSort(0, 0, 8, 200, 1'b0, "R2/R5 full sort");

    // R4 R3: many shared low digits, single pass
    for (int i = 0; i < 256; i++) begin
      logic [7:0] lo;
      case ($urandom % 4)
        0: lo = 8'h03; 1: lo = 8'h07; 2: lo = 8'h03; default: lo = 8'hF0;
      endcase
      stim[i] = {$urandom, 24'($urandom), lo};
    end
    runSort(0, 0, 1, 256, 1'b0, "R4/R3 stable buckets");

    // R2: digit select on index 2
    for (int i = 0; i < 100; i++) stim[i] = {$urandom, $urandom};
    runSort(0, 2, 1, 100, 1'b0, "R2 digit select");

    // R6: one bucket only after a crowded run
    for (int i = 0; i < 30; i++) stim[i] = {$urandom, 24'($urandom), 8'hFF};
    runSort(0, 0, 1, 30, 1'b0, "R6 cleared counts");

    // R11: empty buffer
    runSort(0, 0, 3, 0, 1'b0, "R11 empty");

    // R8: single key
    stim[0] = 64'hFEDC_BA98_7654_3210;
    runSort(0, 0, 8, 1, 1'b0, "R8 single key");

    // R5: descending buffer
    for (int i = 0; i < 128; i++) stim[i] = 64'hFFFF_FFFF_FFFF_FFFF - 64'(i) * 64'h0101_0101_0101_0101;
    runSort(0, 0, 8, 128, 1'b0, "R5 descending");

    // R4: identical keys
    for (int i = 0; i < 64; i++) stim[i] = 64'h1234_5678_9ABC_DEF0;
    runSort(0, 0, 2, 64, 1'b0, "R4 identical");

    // R10: stray start pulse mid-run
    for (int i = 0; i < 50; i++) stim[i] = {$urandom, $urandom};
    runSort(0, 0, 2, 50, 1'b1, "R10 stray start");

    // R9: 13-bit digits, five passes cover all 64 bits
    for (int i = 0; i < 40; i++) stim[i] = {$urandom, $urandom};
    stim[5] = stim[17];
    runSort(1, 0, 5, 40, 1'b0, "R9 wide digit");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule